// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog timer sitting on a 16-bit register bus. An 8-bit up-counter advances on ticks from a prescaler whose divisor comes from a 3-bit select field. When the counter steps past 255 it wraps to zero and raises a sticky overflow flag. In watchdog mode, with the reset enable set, the same overflow also drives a one-clock system reset pulse. Software keeps the system alive by reloading the counter before it wraps.

Each register write has to carry the right key in the upper byte of the bus word. Without it the write is dropped and no state changes, so a stray store cannot stop or reload the timer. The overflow flag clears only through a dedicated command word. That command is honoured only when software has read the flag since the flag was last set.

Top module: `wdg_top`

## Requirements
- R1: After synchronous reset, all three registers read 0x0000 and `sys_rst_o` is low.
- R2: A write to offset 0 whose bits 15:8 are 0xA5 loads the watchdog-mode bit (bit 6), the run bit (bit 5) and the clock select (bits 2:0). A read of offset 0 returns exactly those bits, with every other bit zero. A write to offset 0 with any other key byte is ignored.
- R3: A write to offset 2 whose bits 15:8 are 0x5A loads bits 7:0 into the counter and restarts the prescaler phase. A write to offset 2 with any other key byte leaves the counter unchanged. A read of offset 2 returns the counter in bits 7:0.
- R4: A write to offset 4 whose bits 15:8 are 0x5A loads the reset enable from bit 6. A read of offset 4 returns the overflow flag in bit 7 and the reset enable in bit 6. A word with key 0xA5 other than exactly 0xA500 changes nothing.
- R5: While the run bit is set, the counter increments once every D clocks. D is 1, 64, 128, 256, 512, 1024, 4096 or 16384 for select values 0 to 7. With the counter loaded to 254 at the edge that sets the run bit, overflow happens on the edge 2*D clocks later.
- R6: While the run bit is clear, the counter holds its value.
- R7: A tick with the counter at 255 wraps the counter to 0 and sets the overflow flag.
- R8: An overflow drives `sys_rst_o` high for exactly one clock, and only when both watchdog mode and the reset enable are set. Otherwise the pulse is suppressed, but the flag is still set.
- R9: Writing exactly 0xA500 to offset 4 clears the overflow flag only if offset 4 was read while the flag was set, after the flag was last set. Otherwise the flag stays set.
- R10: `rd_data` is registered and valid the clock after `rd_en`. Its upper byte is always zero. Offsets other than 0, 2 and 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write word: key in bits 15:8, payload in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |
| sys_rst_o | output | 1 | One-clock system reset pulse |

## Verification
A wrong prescaler phase or divisor shows up as an overflow pulse on the wrong clock. For select 7 this can be up to 32768 clocks after the counter is loaded, so each divisor is timed exactly, to the clock. A wrongly armed or disarmed flag is visible at the next read of offset 4 after a clear command. A key-decode error shows at the next readback of the register that was written. A reset pulse that is stretched or wrongly gated shows on `sys_rst_o` one clock after the overflow edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int DATA_W   = 16;
  localparam int KEY_W    = DATA_W / 2;
  localparam int OFF_CTL  = 0;
  localparam int OFF_CNT  = 2;
  localparam int OFF_RCE  = 4;
  localparam logic [KEY_W-1:0]  KEY_CTL   = 8'hA5;
  localparam logic [KEY_W-1:0]  KEY_CNT   = 8'h5A;
  localparam logic [DATA_W-1:0] CLR_WORD  = 16'hA500;

  // clocks per counter tick for a given clock select value
  function automatic int unsigned div_of(input int sel);
    case (sel)
      0:       div_of = 1;
      6:       div_of = 4096;
      7:       div_of = 16384;
      default: div_of = 32'd1 << (5 + sel);
    endcase
  endfunction
endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int SEL_W = 3,
  parameter int PRE_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  import wdg_pkg::*;
  logic [PRE_W-1:0] phase_q;
  logic [PRE_W-1:0] limit;

  always_comb begin
    limit = PRE_W'(div_of(int'(sel)) - 1);
    tick  = run && !restart && (phase_q == limit);
  end

  always_ff @(posedge clk) begin
    if (rst || !run || restart || tick) phase_q <= '0;
    else                                phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/wdg_count.sv
module wdg_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;
  assign cnt  = cnt_q;
  assign wrap = tick && !load && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdg_flag.sv
module wdg_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic seen,
  input  logic clr_req,
  output logic ovf,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ovf   <= 1'b0;
      armed <= 1'b0;
    end else if (set) begin
      ovf   <= 1'b1;
      armed <= 1'b0;
    end else if (clr_req && armed) begin
      ovf   <= 1'b0;
      armed <= 1'b0;
    end else if (seen && ovf) begin
      armed <= 1'b1;
    end
  end
endmodule

// File: rtl/wdg_top.sv
module wdg_top #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8,
  parameter int SEL_W  = 3,
  parameter int PRE_W  = 14
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wr_en,
  input  logic [wdg_pkg::DATA_W-1:0] wr_data,
  input  logic                       rd_en,
  output logic [wdg_pkg::DATA_W-1:0] rd_data,
  output logic                       sys_rst_o
);
  import wdg_pkg::*;

  logic             mode_q, run_q, rste_q;
  logic [SEL_W-1:0] sel_q;
  logic             hit_ctl, hit_cnt, hit_rce;
  logic             wr_ctl, wr_cnt, wr_rce, clr_req;
  logic             tick, wrap, ovf, armed;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    hit_ctl = (addr == ADDR_W'(OFF_CTL));
    hit_cnt = (addr == ADDR_W'(OFF_CNT));
    hit_rce = (addr == ADDR_W'(OFF_RCE));
    wr_ctl  = wr_en && hit_ctl && (wr_data[DATA_W-1:KEY_W] == KEY_CTL);
    wr_cnt  = wr_en && hit_cnt && (wr_data[DATA_W-1:KEY_W] == KEY_CNT);
    wr_rce  = wr_en && hit_rce && (wr_data[DATA_W-1:KEY_W] == KEY_CNT);
    clr_req = wr_en && hit_rce && (wr_data == CLR_WORD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= 1'b0;
      run_q  <= 1'b0;
      sel_q  <= '0;
      rste_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        mode_q <= wr_data[6];
        run_q  <= wr_data[5];
        sel_q  <= wr_data[SEL_W-1:0];
      end
      if (wr_rce) rste_q <= wr_data[6];
    end
  end

  wdg_prescaler #(.SEL_W(SEL_W), .PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .run(run_q), .restart(wr_cnt), .sel(sel_q), .tick(tick)
  );

  wdg_count #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .load(wr_cnt),
    .load_val(wr_data[CNT_W-1:0]), .cnt(cnt), .wrap(wrap)
  );

  wdg_flag flag_i (
    .clk(clk), .rst(rst), .set(wrap), .seen(rd_en && hit_rce),
    .clr_req(clr_req), .ovf(ovf), .armed(armed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_o <= 1'b0;
      rd_data   <= '0;
    end else begin
      sys_rst_o <= wrap && mode_q && rste_q;
      if (rd_en) begin
        rd_data <= '0;
        if (hit_ctl) rd_data <= DATA_W'({mode_q, run_q, 2'b00, sel_q});
        if (hit_cnt) rd_data <= DATA_W'(cnt);
        if (hit_rce) rd_data <= DATA_W'({ovf, rste_q, 6'b0});
      end
    end
  end
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk #(
  parameter int ADDR_W = 3,
  parameter int CNT_W  = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic [ADDR_W-1:0]          addr,
  input logic                       wr_en,
  input logic [wdg_pkg::DATA_W-1:0] wr_data,
  input logic                       run,
  input logic                       mode,
  input logic                       rste,
  input logic                       ovf,
  input logic [CNT_W-1:0]           cnt,
  input logic                       sys_rst_o
);
  import wdg_pkg::*;

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |=> !sys_rst_o);                                       // R8
  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> $past(mode && rste));                              // R8
  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    sys_rst_o |-> ovf);                                              // R7
  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run && !(wr_en && addr == ADDR_W'(OFF_CNT))) |=> $stable(cnt)); // R6
  AST_CNT_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
    (!run && wr_en && addr == ADDR_W'(OFF_CNT) &&
     wr_data[DATA_W-1:KEY_W] != KEY_CNT) |=> $stable(cnt));          // R3
  AST_CTL_BAD_KEY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CTL) &&
     wr_data[DATA_W-1:KEY_W] != KEY_CTL) |=> $stable({mode, run}));  // R2
  AST_CLEAR_BY_CMD: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf) |-> $past(wr_en && addr == ADDR_W'(OFF_RCE) &&
                         wr_data == CLR_WORD));                      // R9
endmodule

bind wdg_top wdg_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .run(run_q), .mode(mode_q), .rste(rste_q), .ovf(ovf), .cnt(cnt),
  .sys_rst_o(sys_rst_o)
);

// File: tb/wdg_top_tb_top.sv
module wdg_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        sys_rst_o;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdg_top dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .sys_rst_o(sys_rst_o)
  );

  function automatic int divisor(input int s);
    int tbl[8] = '{1, 64, 128, 256, 512, 1024, 4096, 16384};
    return tbl[s];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  // edges counted from the last write edge until the pulse is seen
  task automatic wait_pulse(input int cap, output int n);
    n = 0;
    while (n <= cap) begin
      @(negedge clk); n++;
      if (sys_rst_o) break;
    end
  endtask

  task automatic quiet(input int cyc, input string tag);
    int seen = 0;
    repeat (cyc) begin @(negedge clk); if (sys_rst_o) seen = 1; end
    chk(tag, seen, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int n;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    chk("R1 pulse", int'(sys_rst_o), 0);
    rd(3'd0, v); chk("R1 ctl", v, 0);
    rd(3'd2, v); chk("R1 cnt", v, 0);
    rd(3'd4, v); chk("R1 rce", v, 0);

    wr(3'd0, 16'hA5DF); rd(3'd0, v); chk("R2 ctl fields", v, 16'h0047);
    wr(3'd0, 16'h5A00); rd(3'd0, v); chk("R2 bad key ignored", v, 16'h0047);
    wr(3'd0, 16'hA500); rd(3'd0, v); chk("R2 stop word", v, 0);

    wr(3'd2, 16'h5A3C); rd(3'd2, v); chk("R3 cnt load", v, 16'h003C);
    wr(3'd2, 16'h5B11); rd(3'd2, v); chk("R3 bad key ignored", v, 16'h003C);
    repeat (20) @(negedge clk);
    rd(3'd2, v); chk("R6 stopped holds", v, 16'h003C);

    wr(3'd4, 16'h5AFF); rd(3'd4, v); chk("R4 rste set", v, 16'h0040);
    wr(3'd4, 16'h5A00); rd(3'd4, v); chk("R4 rste clear", v, 0);
    wr(3'd4, 16'hA540); rd(3'd4, v); chk("R4 A5 non-clear ignored", v, 0);
    wr(3'd4, 16'h5A40); rd(3'd4, v); chk("R4 rste again", v, 16'h0040);
    rd(3'd6, v); chk("R10 unmapped offset", v, 0);

    // divisor sweep, watchdog mode with reset enabled
    for (int s = 0; s < 8; s++) begin
      wr(3'd0, 16'hA500);
      wr(3'd2, 16'h5AFE);
      wr(3'd0, 16'hA560 | 16'(s));
      wait_pulse(2 * divisor(s) + 4, n);
      chk($sformatf("R5 overflow edge sel %0d", s), n, 2 * divisor(s));
      @(negedge clk);
      chk($sformatf("R8 pulse width sel %0d", s), int'(sys_rst_o), 0);
      wr(3'd0, 16'hA500);
      if (s > 0) begin
        rd(3'd2, v); chk($sformatf("R7 wrap to zero sel %0d", s), v, 0);
      end
      if (s == 0) begin
        wr(3'd4, 16'hA500);
        rd(3'd4, v); chk("R9 clear without read kept", v, 16'h00C0);
      end else begin
        rd(3'd4, v); chk($sformatf("R7 flag set sel %0d", s), v, 16'h00C0);
      end
      wr(3'd4, 16'hA500);
      rd(3'd4, v); chk($sformatf("R9 clear after read sel %0d", s), v, 16'h0040);
    end

    // counter reload while running restarts the prescaler phase
    wr(3'd2, 16'h5A10);
    wr(3'd0, 16'hA561);
    repeat (40) @(negedge clk);
    wr(3'd2, 16'h5AFE);
    wait_pulse(200, n); chk("R3 reload restarts phase", n, 128);
    wr(3'd0, 16'hA500);
    rd(3'd4, v); wr(3'd4, 16'hA500);

    // interval mode: flag but no pulse
    wr(3'd2, 16'h5AFE);
    wr(3'd0, 16'hA520);
    quiet(6, "R8 no pulse in interval mode");
    wr(3'd0, 16'hA500);
    rd(3'd4, v); chk("R8 interval flag set", v, 16'h00C0);
    wr(3'd4, 16'hA500);

    // watchdog mode with reset disabled
    wr(3'd4, 16'h5A00);
    wr(3'd2, 16'h5AFE);
    wr(3'd0, 16'hA560);
    quiet(6, "R8 no pulse with rste clear");
    wr(3'd0, 16'hA500);
    rd(3'd4, v); chk("R8 flag without rste", v, 16'h0080);
    wr(3'd4, 16'hA500);
    rd(3'd4, v); chk("R9 cleared", v, 0);
    rd(3'd0, v); chk("R10 upper byte zero", int'(v[15:8]), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule